// File: doc/BRIEF.md
# Interrupt Flag Unit with Serial Clear-on-Read Access

This block collects up to eight internal event pulses into sticky flag bits. Each flag bit also has a mask bit. While any flag that is also unmasked is set, an active-low interrupt line toward the host is pulled low. Flags are recorded whether or not their mask bit is set.

The host reaches the block through a byte-oriented serial slave port with chip select, serial clock, data in and data out. Each transaction has two bytes. The first byte is a command, and the second carries data in the direction the command selects. Three addresses are decoded:

- the flag register, read-only, which can be read without side effects;
- the mask register, which can be read and written;
- a clear-on-read view of the flags at address 05h.

During a clear-on-read transaction the interrupt line is released from the end of the command byte until the data byte has been fully shifted out. It then reflects whatever arrived in the meantime, so no event is lost. All serial pins are synchronized into the system clock domain, and their edges are detected there.

Top module: `irq_serial_unit`

## Requirements
- R1: A one-cycle pulse on any bit of `evt_i` sets the matching flag bit, whatever its mask bit holds. The flag stays set until a completed clear-on-read transaction reports it.
- R2: `irq_n_o` is low exactly when some flag bit and its mask bit are both 1, outside a clear-on-read window. It follows the flags and mask with one clock of register delay.
- R3: A read of address 04h returns the flag register and leaves it unchanged.
- R4: A write to address 0Ah loads the mask register with the data byte. A read of address 0Ah returns the mask.
- R5: A read of address 05h returns the flags as they stood at the end of the command byte. When the transaction completes, every flag it reported is cleared.
- R6: In a clear-on-read transaction, `irq_n_o` goes high after the eighth falling SCLK edge, which is the last bit of the command byte. It stays high until the sixteenth falling edge.
- R7: After the sixteenth falling edge of a clear-on-read transaction, `irq_n_o` goes low again if any flag that arrived during the window is unmasked. Otherwise it stays high.
- R8: An event that arrives between the eighth and sixteenth falling edges of a clear-on-read transaction is kept as a set flag after the clear. This holds even when the same bit was reported and cleared by that transaction.
- R9: If chip select rises before the sixteenth falling edge, the transaction is aborted. No flag is cleared, events that arrived during the window are kept, and `irq_n_o` returns to the level R2 gives.
- R10: The command byte format is as follows:
  - bit 7 = 1 means write, and bits 6:0 hold the address;
  - both bytes are sent MSB first;
  - DIN is sampled on falling SCLK edges, and DOUT changes after rising edges;
  - reads of any address other than 04h, 05h and 0Ah return 0;
  - writes to any address other than 0Ah have no effect.
- R11: After synchronous reset, flags and mask are 0, `irq_n_o` is 1 and `dout_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 8 | One-cycle event pulses, one per flag bit |
| cs_n_i | input | 1 | Serial chip select, active low |
| sclk_i | input | 1 | Serial clock from the host, idle high |
| din_i | input | 1 | Serial data from the host |
| dout_o | output | 1 | Serial data to the host |
| irq_n_o | output | 1 | Interrupt request, active low |

## Verification
The hardest situation to reach from the ports is an event landing inside the clear-on-read window. This includes the case where the event hits a bit that the same transaction is reporting and clearing, and the case where it arrives on the very last falling edge. The bench's transfer task can inject an event mask at any chosen bit slot of the frame, and it can stop a frame early by raising chip select. Together these steer events into the window start, the middle and the end, and into transactions aborted during the data byte. A behavioural model that follows the synchronized pin history is compared against the interrupt and data-out pins on every clock.

// File: rtl/irqsr_pkg.sv
package irqsr_pkg;
  parameter int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = BYTE_W - 1;

  typedef struct packed {
    logic              wr;
    logic [ADDR_W-1:0] addr;
  } cmd_t;
endpackage

// File: rtl/irqsr_sync.sv
module irqsr_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/irqsr_frame.sv
module irqsr_frame
  import irqsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_s,
  input  logic              sclk_s,
  input  logic              din_s,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic              dout_o,
  output logic              cmd_done,
  output cmd_t              cmd_word,
  output logic              end_done,
  output logic [BYTE_W-1:0] wr_word,
  output logic              abort,
  output cmd_t              cmd_q
);
  localparam int unsigned FRAME_BITS = 2 * BYTE_W;
  localparam int unsigned CNT_W      = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] LAST_CMD = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] FIRST_DAT = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_DAT = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] DONE     = CNT_W'(FRAME_BITS);

  logic             sclk_d, cs_d;
  logic             fall, rise, cs_rise;
  logic [CNT_W-1:0] cnt;
  logic [BYTE_W-1:0] cmd_sh, rx_sh, tx_sh;
  logic             in_data;

  assign fall    = sclk_d & ~sclk_s & ~cs_s;
  assign rise    = ~sclk_d & sclk_s & ~cs_s;
  assign cs_rise = cs_s & ~cs_d;
  assign in_data = (cnt >= FIRST_DAT) && (cnt <= LAST_DAT);

  assign cmd_word = cmd_t'({cmd_sh[BYTE_W-2:0], din_s});
  assign wr_word  = {rx_sh[BYTE_W-2:0], din_s};
  assign cmd_done = fall && (cnt == LAST_CMD);
  assign end_done = fall && (cnt == LAST_DAT);
  assign abort    = cs_rise && (cnt != '0) && (cnt != DONE);
  assign cmd_q    = cmd_t'(cmd_sh);

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d <= 1'b1;
      cs_d   <= 1'b1;
    end else begin
      sclk_d <= sclk_s;
      cs_d   <= cs_s;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      cmd_sh <= '0;
      rx_sh  <= '0;
      tx_sh  <= '0;
      dout_o <= 1'b0;
    end else if (cs_s) begin
      cnt    <= '0;
      dout_o <= 1'b0;
    end else begin
      if (fall && (cnt != DONE)) begin
        cnt <= cnt + 1'b1;
        if (cnt < FIRST_DAT) cmd_sh <= cmd_word;
        else                 rx_sh  <= wr_word;
        if (cnt == LAST_CMD) tx_sh <= cmd_word.wr ? '0 : rd_byte;
      end
      if (rise && in_data && !cmd_q.wr) begin
        dout_o <= tx_sh[BYTE_W-1];
        tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/irqsr_core.sv
module irqsr_core
  import irqsr_pkg::*;
#(
  parameter logic [ADDR_W-1:0] ADDR_STATUS = ADDR_W'(7'h04),
  parameter logic [ADDR_W-1:0] ADDR_RDCLR  = ADDR_W'(7'h05),
  parameter logic [ADDR_W-1:0] ADDR_ENABLE = ADDR_W'(7'h0A)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] evt_i,
  input  logic              cmd_done,
  input  cmd_t              cmd_word,
  input  logic              end_done,
  input  logic [BYTE_W-1:0] wr_word,
  input  logic              abort,
  input  cmd_t              cmd_q,
  output logic [BYTE_W-1:0] rd_byte,
  output logic              irq_n_o,
  output logic [BYTE_W-1:0] status_q,
  output logic [BYTE_W-1:0] enable_q,
  output logic [BYTE_W-1:0] shadow_q,
  output logic              win_q
);
  logic win_start, win_stop;

  always_comb begin
    rd_byte = '0;
    if (!cmd_word.wr) begin
      if (cmd_word.addr == ADDR_STATUS || cmd_word.addr == ADDR_RDCLR)
        rd_byte = status_q;
      else if (cmd_word.addr == ADDR_ENABLE)
        rd_byte = enable_q;
    end
  end

  assign win_start = cmd_done && !cmd_word.wr && (cmd_word.addr == ADDR_RDCLR);
  assign win_stop  = win_q && (end_done || abort);

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      shadow_q <= '0;
      win_q    <= 1'b0;
      irq_n_o  <= 1'b1;
    end else begin
      irq_n_o <= win_q | ~|(status_q & enable_q);
      if (win_start) begin
        shadow_q <= evt_i;
        win_q    <= 1'b1;
      end else if (win_stop) begin
        status_q <= (end_done ? '0 : status_q) | shadow_q | evt_i;
        shadow_q <= '0;
        win_q    <= 1'b0;
      end else if (win_q) begin
        shadow_q <= shadow_q | evt_i;
      end else begin
        status_q <= status_q | evt_i;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      enable_q <= '0;
    else if (end_done && cmd_q.wr && (cmd_q.addr == ADDR_ENABLE))
      enable_q <= wr_word;
  end
endmodule

// File: rtl/irq_serial_unit.sv
module irq_serial_unit
  import irqsr_pkg::*;
#(
  parameter int unsigned       SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] ADDR_STATUS = ADDR_W'(7'h04),
  parameter logic [ADDR_W-1:0] ADDR_RDCLR  = ADDR_W'(7'h05),
  parameter logic [ADDR_W-1:0] ADDR_ENABLE = ADDR_W'(7'h0A)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] evt_i,
  input  logic              cs_n_i,
  input  logic              sclk_i,
  input  logic              din_i,
  output logic              dout_o,
  output logic              irq_n_o
);
  logic [2:0]        pins_s;
  logic              cmd_done, end_done, abort;
  cmd_t              cmd_word, cmd_q;
  logic [BYTE_W-1:0] wr_word, rd_byte;
  logic [BYTE_W-1:0] status_q, enable_q, shadow_q;
  logic              win_q;

  irqsr_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({cs_n_i, sclk_i, din_i}),
    .q   (pins_s)
  );

  irqsr_frame u_frame (
    .clk      (clk),
    .rst      (rst),
    .cs_s     (pins_s[2]),
    .sclk_s   (pins_s[1]),
    .din_s    (pins_s[0]),
    .rd_byte  (rd_byte),
    .dout_o   (dout_o),
    .cmd_done (cmd_done),
    .cmd_word (cmd_word),
    .end_done (end_done),
    .wr_word  (wr_word),
    .abort    (abort),
    .cmd_q    (cmd_q)
  );

  irqsr_core #(
    .ADDR_STATUS (ADDR_STATUS),
    .ADDR_RDCLR  (ADDR_RDCLR),
    .ADDR_ENABLE (ADDR_ENABLE)
  ) u_core (
    .clk      (clk),
    .rst      (rst),
    .evt_i    (evt_i),
    .cmd_done (cmd_done),
    .cmd_word (cmd_word),
    .end_done (end_done),
    .wr_word  (wr_word),
    .abort    (abort),
    .cmd_q    (cmd_q),
    .rd_byte  (rd_byte),
    .irq_n_o  (irq_n_o),
    .status_q (status_q),
    .enable_q (enable_q),
    .shadow_q (shadow_q),
    .win_q    (win_q)
  );
endmodule

// File: rtl/irqsr_chk.sv
module irqsr_chk
  import irqsr_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [BYTE_W-1:0] evt_i,
  input logic              irq_n_o,
  input logic [BYTE_W-1:0] status_q,
  input logic [BYTE_W-1:0] enable_q,
  input logic [BYTE_W-1:0] shadow_q,
  input logic              win_q
);
  // R6
  win_release_chk: assert property (@(posedge clk) disable iff (rst)
    win_q |=> irq_n_o);

  // R2
  irq_assert_chk: assert property (@(posedge clk) disable iff (rst)
    (!win_q && (|(status_q & enable_q))) |=> !irq_n_o);

  // R2
  irq_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!win_q && !(|(status_q & enable_q))) |=> irq_n_o);

  // R1
  sticky_flag_chk: assert property (@(posedge clk) disable iff (rst)
    !win_q |=> ((status_q & $past(status_q)) == $past(status_q)));

  // R8
  evt_kept_chk: assert property (@(posedge clk) disable iff (rst)
    (|evt_i) |=> (((status_q | shadow_q) & $past(evt_i)) == $past(evt_i)));
endmodule

bind irq_serial_unit irqsr_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .evt_i    (evt_i),
  .irq_n_o  (irq_n_o),
  .status_q (status_q),
  .enable_q (enable_q),
  .shadow_q (shadow_q),
  .win_q    (win_q)
);

// File: tb/sim_irq_serial_unit.sv
`timescale 1ns/1ps
module sim_irq_serial_unit;
  localparam int H = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] evt = '0;
  logic       cs_n = 1'b1, sclk = 1'b1, din = 1'b0;
  logic       dout, irq_n;
  int         n_cmp = 0, n_bad = 0;
  bit         done = 0;

  always #10 clk = ~clk;

  irq_serial_unit u0 (
    .clk(clk), .rst(rst), .evt_i(evt), .cs_n_i(cs_n), .sclk_i(sclk),
    .din_i(din), .dout_o(dout), .irq_n_o(irq_n)
  );

  // ---------------- behavioural reference model ----------------
  logic [2:0] hq[$];
  int         m_cnt;
  logic [7:0] m_cmd, m_rx, m_tx, m_st, m_en, m_sh;
  logic       m_win, m_dout, m_irq;

  function automatic logic [7:0] peek(logic [7:0] cw);
    if (cw[7]) return 8'h00;
    case (cw[6:0])
      7'h04, 7'h05: return m_st;
      7'h0A:        return m_en;
      default:      return 8'h00;
    endcase
  endfunction

  always @(posedge clk) begin : mdl
    logic [2:0] c, p;
    logic       fall, rise, csr, cmdp, endp, abt, start, n_irq;
    logic [7:0] cw, ww, rb;
    if (rst) begin
      hq.delete();
      repeat (4) hq.push_back(3'b110);
      m_cnt = 0; m_cmd = 0; m_rx = 0; m_tx = 0; m_st = 0; m_en = 0; m_sh = 0;
      m_win = 0; m_dout = 0; m_irq = 1;
    end else begin
      hq.push_front({cs_n, sclk, din});
      void'(hq.pop_back());
      c = hq[2]; p = hq[3];
      n_irq = m_win ? 1'b1 : ~|(m_st & m_en);
      fall = ~c[2] & p[1] & ~c[1];
      rise = ~c[2] & ~p[1] & c[1];
      csr  = c[2] & ~p[2];
      cw   = {m_cmd[6:0], c[0]};
      ww   = {m_rx[6:0], c[0]};
      cmdp = fall && m_cnt == 7;
      endp = fall && m_cnt == 15;
      abt  = csr && m_cnt != 0 && m_cnt != 16;
      rb   = peek(cw);
      start = cmdp && !cw[7] && cw[6:0] == 7'h05;
      if (start) begin m_sh = evt; m_win = 1; end
      else if (m_win && (endp || abt)) begin
        m_st = (endp ? 8'h00 : m_st) | m_sh | evt; m_sh = 0; m_win = 0;
      end else if (m_win) m_sh = m_sh | evt;
      else m_st = m_st | evt;
      if (endp && m_cmd[7] && m_cmd[6:0] == 7'h0A) m_en = ww;
      if (c[2]) begin m_cnt = 0; m_dout = 0; end
      else begin
        if (fall && m_cnt != 16) begin
          if (m_cnt < 8) m_cmd = cw; else m_rx = ww;
          if (m_cnt == 7) m_tx = cw[7] ? 8'h00 : rb;
          m_cnt++;
        end
        if (rise && m_cnt >= 8 && m_cnt <= 15 && !m_cmd[7]) begin
          m_dout = m_tx[7]; m_tx = {m_tx[6:0], 1'b0};
        end
      end
      m_irq = n_irq;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      n_cmp++;
      if (irq_n !== m_irq) begin
        n_bad++;
        $display("FAIL R2 model irq_n actual=%b expected=%b at %0t", irq_n, m_irq, $time);
      end
      n_cmp++;
      if (dout !== m_dout) begin
        n_bad++;
        $display("FAIL R10 model dout actual=%b expected=%b at %0t", dout, m_dout, $time);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(logic [7:0] m);
    evt = m; tick(1); evt = '0; tick(3);
  endtask

  task automatic xfer(input logic [7:0] cmd, input logic [7:0] wd,
                      input int inj_at, input logic [7:0] inj_m, input int stop_at,
                      output logic [7:0] rd, output logic mid);
    rd = '0; mid = 1'bx;
    cs_n = 1'b0; tick(H);
    for (int i = 0; i < 16; i++) begin
      if (i == stop_at) break;
      din = (i < 8) ? cmd[7-i] : wd[15-i];
      tick(H);
      if (i >= 8) rd[15-i] = dout;
      if (i == 12) mid = irq_n;
      sclk = 1'b0;
      if (i == inj_at) begin evt = inj_m; tick(1); evt = '0; tick(H-1); end
      else tick(H);
      sclk = 1'b1;
    end
    tick(H); cs_n = 1'b1; tick(H + 2);
  endtask

  task automatic reg_rd(input logic [6:0] a, output logic [7:0] d);
    logic m;
    xfer({1'b0, a}, 8'h00, -1, 8'h00, 99, d, m);
  endtask

  task automatic reg_wr(input logic [6:0] a, input logic [7:0] d);
    logic [7:0] r; logic m;
    xfer({1'b1, a}, d, -1, 8'h00, 99, r, m);
  endtask

  // ---------------- stimulus ----------------
  initial begin : stim
    logic [7:0] d;
    logic       mid;
    tick(5); rst = 1'b0; tick(2);
    // R11 reset state
    chk("R11 irq_n after reset", {7'd0, irq_n}, 8'h01);
    chk("R11 dout after reset", {7'd0, dout}, 8'h00);
    reg_rd(7'h0A, d); chk("R11 mask after reset", d, 8'h00);
    reg_rd(7'h04, d); chk("R11 flags after reset", d, 8'h00);

    // R1 flags set with mask clear; R2 no request
    pulse(8'h11);
    chk("R2 irq_n masked", {7'd0, irq_n}, 8'h01);
    reg_rd(7'h04, d); chk("R1 flags set while masked", d, 8'h11);
    reg_rd(7'h04, d); chk("R3 plain read keeps flags", d, 8'h11);

    // R4 mask write/read, R2 request
    reg_wr(7'h0A, 8'h10);
    reg_rd(7'h0A, d); chk("R4 mask readback", d, 8'h10);
    chk("R2 irq_n asserted", {7'd0, irq_n}, 8'h00);

    // R10 ignored write and unknown address
    reg_wr(7'h04, 8'hFF);
    reg_rd(7'h04, d); chk("R10 write to flags ignored", d, 8'h11);
    reg_rd(7'h33, d); chk("R10 unknown address reads zero", d, 8'h00);
    reg_wr(7'h05, 8'hFF);
    reg_rd(7'h0A, d); chk("R10 write to 05h leaves mask", d, 8'h10);

    // R5 / R6 plain clear-on-read
    xfer(8'h05, 8'h00, -1, 8'h00, 99, d, mid);
    chk("R5 clear-on-read data", d, 8'h11);
    chk("R6 irq_n released mid data", {7'd0, mid}, 8'h01);
    chk("R7 no pending keeps irq_n high", {7'd0, irq_n}, 8'h01);
    reg_rd(7'h04, d); chk("R5 flags cleared", d, 8'h00);

    // R7 / R8 event inside window, overlapping a reported bit
    pulse(8'h30);
    chk("R2 irq_n on new event", {7'd0, irq_n}, 8'h00);
    xfer(8'h05, 8'h00, 10, 8'h12, 99, d, mid);
    chk("R5 reported flags", d, 8'h30);
    chk("R6 irq_n high in window", {7'd0, mid}, 8'h01);
    chk("R7 irq_n reasserts for window event", {7'd0, irq_n}, 8'h00);
    reg_rd(7'h04, d); chk("R8 window event kept", d, 8'h12);

    // R8 event on the final falling edge, masked bit
    xfer(8'h05, 8'h00, 15, 8'h01, 99, d, mid);
    chk("R5 reported flags 2", d, 8'h12);
    chk("R7 masked window event keeps irq_n high", {7'd0, irq_n}, 8'h01);
    reg_rd(7'h04, d); chk("R8 last-edge event kept", d, 8'h01);

    // R9 abort during data byte
    pulse(8'h10);
    xfer(8'h05, 8'h00, 9, 8'h04, 12, d, mid);
    chk("R9 irq_n back after abort", {7'd0, irq_n}, 8'h00);
    reg_rd(7'h04, d); chk("R9 no clear on abort", d, 8'h15);

    // R9 abort during command byte
    xfer(8'h05, 8'h00, -1, 8'h00, 4, d, mid);
    reg_rd(7'h04, d); chk("R9 command abort harmless", d, 8'h15);

    // R2 mask change pattern
    xfer(8'h05, 8'h00, -1, 8'h00, 99, d, mid);
    chk("R5 final clear data", d, 8'h15);
    reg_wr(7'h0A, 8'hFF);
    pulse(8'h80);
    chk("R2 irq_n with full mask", {7'd0, irq_n}, 8'h00);
    reg_wr(7'h0A, 8'h00);
    chk("R2 irq_n after masking", {7'd0, irq_n}, 8'h01);

    tick(4);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog R2 actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule